// File: doc/BRIEF.md
# Character display bring-up sequencer

This block starts a character display that takes writes on an 8-bit parallel bus. It runs on its own with no host attached. After reset it waits out the display's power-up time. It then replays a short fixed script from an internal table: three configuration commands, a greeting word, a command that moves the write position to the second half of the display, and a second word. Each table entry holds a register-select bit, an 8-bit code and a wait class that is either short or long.

For each entry the block drives register select and the code onto the bus, then raises the enable strobe for a fixed number of clocks. It keeps register select and the code on the bus for a few clocks after the strobe falls, then returns the bus to zero. It then waits for the display to execute the write before starting the next entry. The long wait class is used only after the clear command.

When the last entry has been written, the block raises `done` and leaves the bus idle until the next reset. The read/write line is always driven low because the display is never read. All timing values are clock-cycle parameters. The defaults suit a 25 MHz clock: 15 ms power-up, 40 µs short wait, 2 ms long wait and a 240 ns strobe.

Top module: `lcd_boot_seq`

## Requirements
- R1: While reset is asserted, `disp_en`, `disp_rs`, `disp_data` and `done` are all 0. `disp_rw` is 0 at all times.
- R2: After reset is released, the first rise of `disp_en` comes exactly `POWERUP_CYC` clock cycles later, counting the first clock edge with reset inactive as cycle 1.
- R3: Each write holds `disp_en` high for exactly `EN_CYC` consecutive cycles.
- R4: `disp_rs` and `disp_data` reach their new values one cycle before `disp_en` rises. They do not change while `disp_en` is high.
- R5: After `disp_en` falls, `disp_rs` and `disp_data` keep their values for `HOLD_CYC` cycles. On the next cycle both return to 0.
- R6: Exactly eleven writes are issued. The (RS, code) pairs, in order, are:
  - (0,0x38), (0,0x0F), (0,0x01)
  - (1,'R'), (1,'E'), (1,'A'), (1,'D'), (1,'Y')
  - (0,0xC0)
  - (1,'G'), (1,'O')
  
  RS=0 marks a command and RS=1 marks character data. The characters are ASCII.
- R7: After every write other than the clear command (0x01), `disp_en` stays low for exactly `HOLD_CYC + SHORT_WAIT_CYC + 1` cycles before it rises again.
- R8: After the clear command, `disp_en` stays low for exactly `HOLD_CYC + LONG_WAIT_CYC + 1` cycles before the next rise.
- R9: `done` rises `HOLD_CYC + SHORT_WAIT_CYC` clock edges after the edge on which the last write's `disp_en` falls. It then stays high with `disp_en`, `disp_rs` and `disp_data` at 0 until reset.
- R10: A reset asserted part-way through the script restarts it from the first table entry, with the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| disp_rs | output | 1 | Register select: 0 command, 1 character data |
| disp_rw | output | 1 | Read/write select, always 0 (write) |
| disp_en | output | 1 | Enable strobe |
| disp_data | output | 8 | Command or character code |
| done | output | 1 | Script finished, bus idle |

## Verification
The block's only inputs are the clock and an asynchronous reset, so the assertions assume nothing about the bus. They do assume that reset is released away from a rising clock edge. The stimulus ensures this by changing reset a quarter period after a falling edge. The bench shortens every timing parameter so that two passes through the script fit in a short run. The first pass is cut off by reset after five writes. The second pass runs to completion. Every gap, strobe width, hold window and table entry is compared against cycle counts derived from the parameters.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   typedef enum logic [2:0] {
      ST_POWERUP,
      ST_SETUP,
      ST_PULSE,
      ST_HOLD,
      ST_WAIT,
      ST_DONE
   } seq_state_t;

   typedef struct packed {
      logic       long_wait;
      logic       rs;
      logic [7:0] code;
   } seq_entry_t;

   localparam int unsigned SEQ_LEN = 11;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Script table: configuration, clear, first word, second-half jump, second word.
   function automatic seq_entry_t seq_lookup(input int unsigned idx);
      seq_entry_t e;
      e = '0;
      case (idx)
         0:  e = '{1'b0, 1'b0, 8'h38};
         1:  e = '{1'b0, 1'b0, 8'h0F};
         2:  e = '{1'b1, 1'b0, 8'h01};
         3:  e = '{1'b0, 1'b1, 8'h52};
         4:  e = '{1'b0, 1'b1, 8'h45};
         5:  e = '{1'b0, 1'b1, 8'h41};
         6:  e = '{1'b0, 1'b1, 8'h44};
         7:  e = '{1'b0, 1'b1, 8'h59};
         8:  e = '{1'b0, 1'b0, 8'hC0};
         9:  e = '{1'b0, 1'b1, 8'h47};
         10: e = '{1'b0, 1'b1, 8'h4F};
         default: e = '0;
      endcase
      return e;
   endfunction

endpackage

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
   import lcd_seq_pkg::*;
#(
   parameter int unsigned IDX_W = 4,
   parameter int unsigned NPORT = 2
) (
   input  logic [NPORT-1:0][IDX_W-1:0] addr,
   output seq_entry_t [NPORT-1:0]      entry
);

   generate
      for (genvar g = 0; g < NPORT; g++) begin : g_port
         always_comb entry[g] = seq_lookup(32'(addr[g]));
      end
   endgenerate

endmodule

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer #(
   parameter int unsigned     CNT_W   = 19,
   parameter logic [CNT_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= RST_VAL;
      else if (load)     cnt <= load_val;
      else if (cnt != 0) cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // The counter never leaves zero except through a load.
   p_zero_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(zero) && !$past(load)) |-> zero);

endmodule

// File: rtl/lcd_boot_seq.sv
module lcd_boot_seq
   import lcd_seq_pkg::*;
#(
   parameter int unsigned POWERUP_CYC    = 375000,
   parameter int unsigned SHORT_WAIT_CYC = 1000,
   parameter int unsigned LONG_WAIT_CYC  = 50000,
   parameter int unsigned EN_CYC         = 6,
   parameter int unsigned HOLD_CYC       = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic       disp_rs,
   output logic       disp_rw,
   output logic       disp_en,
   output logic [7:0] disp_data,
   output logic       done
);

   localparam int unsigned MAX_CYC = max2(max2(POWERUP_CYC, LONG_WAIT_CYC),
                                          max2(SHORT_WAIT_CYC, max2(EN_CYC, HOLD_CYC)));
   localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
   localparam int unsigned IDX_W   = $clog2(SEQ_LEN + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);
   localparam logic [CNT_W-1:0] PWR_LD   = CNT_W'(POWERUP_CYC - 1);
   localparam logic [CNT_W-1:0] EN_LD    = CNT_W'(EN_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_WAIT_CYC - 1);

   generate
      if (POWERUP_CYC < 1 || EN_CYC < 1 || HOLD_CYC < 1 ||
          SHORT_WAIT_CYC < 1 || LONG_WAIT_CYC < SHORT_WAIT_CYC) begin : g_bad_cfg
         $error("lcd_boot_seq: timing parameters out of range");
      end
   endgenerate

   seq_state_t        state;
   logic [IDX_W-1:0]  idx;
   seq_entry_t [1:0]  rom_q;
   logic [1:0][IDX_W-1:0] rom_a;
   logic              t_load;
   logic [CNT_W-1:0]  t_val;
   logic              t_zero;

   assign rom_a[0] = idx;
   assign rom_a[1] = idx + 1'b1;

   lcd_seq_rom #(.IDX_W(IDX_W), .NPORT(2)) u_rom (
      .addr  (rom_a),
      .entry (rom_q)
   );

   always_comb begin
      t_load = 1'b0;
      t_val  = '0;
      case (state)
         ST_SETUP: begin
            t_load = 1'b1;
            t_val  = EN_LD;
         end
         ST_PULSE: begin
            t_load = t_zero;
            t_val  = HOLD_LD;
         end
         ST_HOLD: begin
            t_load = t_zero;
            t_val  = rom_q[0].long_wait ? LONG_LD : SHORT_LD;
         end
         default: ;
      endcase
   end

   lcd_seq_timer #(.CNT_W(CNT_W), .RST_VAL(PWR_LD)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_POWERUP;
         idx       <= '0;
         disp_en   <= 1'b0;
         disp_rs   <= 1'b0;
         disp_data <= '0;
         done      <= 1'b0;
      end else begin
         case (state)
            ST_POWERUP: if (t_zero) begin
               disp_rs   <= rom_q[0].rs;
               disp_data <= rom_q[0].code;
               state     <= ST_SETUP;
            end
            ST_SETUP: begin
               disp_en <= 1'b1;
               state   <= ST_PULSE;
            end
            ST_PULSE: if (t_zero) begin
               disp_en <= 1'b0;
               state   <= ST_HOLD;
            end
            ST_HOLD: if (t_zero) begin
               disp_rs   <= 1'b0;
               disp_data <= '0;
               state     <= ST_WAIT;
            end
            ST_WAIT: if (t_zero) begin
               if (idx == LAST_IDX) begin
                  done  <= 1'b1;
                  state <= ST_DONE;
               end else begin
                  idx       <= idx + 1'b1;
                  disp_rs   <= rom_q[1].rs;
                  disp_data <= rom_q[1].code;
                  state     <= ST_SETUP;
               end
            end
            default: state <= ST_DONE;
         endcase
      end
   end

   assign disp_rw = 1'b0;

   // Checker state: run lengths of the strobe, saturating.
   logic [CNT_W-1:0] en_hi_run, en_lo_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_hi_run <= '0;
         en_lo_run <= '0;
      end else begin
         en_hi_run <= disp_en ? ((&en_hi_run) ? en_hi_run : en_hi_run + 1'b1) : '0;
         en_lo_run <= disp_en ? '0 : ((&en_lo_run) ? en_lo_run : en_lo_run + 1'b1);
      end
   end

   p_en_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(disp_en) |-> (en_hi_run == CNT_W'(EN_CYC)));

   p_bus_stable_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_en && $past(disp_en)) |-> ($stable(disp_data) && $stable(disp_rs)));

   p_setup_before_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_en) |-> ($stable(disp_data) && $stable(disp_rs)));

   p_hold_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(disp_en) |-> ($stable(disp_data) && $stable(disp_rs)));

   p_gap_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_en) |-> (en_lo_run >= CNT_W'(HOLD_CYC + SHORT_WAIT_CYC + 1)));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!disp_en && !disp_rs && disp_data == 8'h00));

   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done) |-> done);

endmodule

// File: tb/sim_lcd_boot_seq.sv
module sim_lcd_boot_seq;
   import lcd_seq_pkg::*;

   localparam int CLK_PER = 40;
   localparam int P_PWR   = 300;
   localparam int P_SHORT = 20;
   localparam int P_LONG  = 150;
   localparam int P_EN    = 6;
   localparam int P_HOLD  = 2;
   localparam int N_WR    = 11;
   localparam int LIMIT   = 20000;
   localparam int AFTER_DONE = 50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic disp_rs, disp_rw, disp_en, done;
   logic [7:0] disp_data;

   always #(CLK_PER/2) clk = ~clk;

   lcd_boot_seq #(
      .POWERUP_CYC(P_PWR), .SHORT_WAIT_CYC(P_SHORT), .LONG_WAIT_CYC(P_LONG),
      .EN_CYC(P_EN), .HOLD_CYC(P_HOLD)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .disp_rs(disp_rs), .disp_rw(disp_rw),
      .disp_en(disp_en), .disp_data(disp_data), .done(done)
   );

   int nchk = 0, nbad = 0, wd_bad = 0, cyc = 0;
   int nwr = 0, lo_run = 0, hi_run = 0, post = 0;
   bit prev_en = 0, have_wr = 0, done_q = 0, hi_ok = 1, rst_chk = 0, fin = 0;
   bit second_run = 0;
   logic [7:0] prev_d = '0, cap_d = '0;
   logic prev_rs = 0, cap_rs = 0, cap_long = 0;

   // Expected script: {long_wait, rs, code}
   function automatic logic [9:0] exp_entry(input int i);
      case (i)
         0: return {1'b0, 1'b0, 8'h38};
         1: return {1'b0, 1'b0, 8'h0F};
         2: return {1'b1, 1'b0, 8'h01};
         3: return {1'b0, 1'b1, "R"};
         4: return {1'b0, 1'b1, "E"};
         5: return {1'b0, 1'b1, "A"};
         6: return {1'b0, 1'b1, "D"};
         7: return {1'b0, 1'b1, "Y"};
         8: return {1'b0, 1'b0, 8'hC0};
         9: return {1'b0, 1'b1, "G"};
         10: return {1'b0, 1'b1, "O"};
         default: return 10'h3FF;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         if (!rst_chk) begin
            chk(!disp_en && !disp_rs && disp_data == 0 && !done && !disp_rw, "R1 reset state",
                {disp_en, disp_rs, done, disp_data}, 0);
            rst_chk = 1;
         end
         nwr = 0; lo_run = 0; hi_run = 0; post = 0;
         prev_en = 0; have_wr = 0; done_q = 0; hi_ok = 1;
         prev_d = '0; prev_rs = 0; cap_long = 0;
      end else begin
         rst_chk = 0;
         if (disp_en) begin
            if (!prev_en) begin
               if (!have_wr)
                  chk(lo_run == P_PWR, "R2 power-up wait", lo_run, P_PWR);
               else if (cap_long)
                  chk(lo_run == P_HOLD + P_LONG + 1, "R8 gap after clear", lo_run, P_HOLD + P_LONG + 1);
               else
                  chk(lo_run == P_HOLD + P_SHORT + 1, "R7 short gap", lo_run, P_HOLD + P_SHORT + 1);
               chk(disp_data == prev_d && disp_rs == prev_rs, "R4 setup cycle",
                   {disp_rs, disp_data}, {prev_rs, prev_d});
               chk(!done_q, "R9 no write after done", done_q, 0);
               hi_run = 1; hi_ok = 1;
            end else begin
               hi_run++;
               if (disp_data != prev_d || disp_rs != prev_rs) hi_ok = 0;
            end
         end else begin
            if (prev_en) begin
               logic [9:0] e;
               chk(hi_run == P_EN, "R3 strobe width", hi_run, P_EN);
               chk(hi_ok, "R4 stable while high", hi_ok, 1);
               chk(disp_rw == 0, "R1 rw low", disp_rw, 0);
               e = exp_entry(nwr);
               chk({disp_rs, disp_data} == e[8:0], "R6 write order", {disp_rs, disp_data}, e[8:0]);
               if (second_run && nwr == 0)
                  chk({disp_rs, disp_data} == 9'h038, "R10 restart from first entry",
                      {disp_rs, disp_data}, 9'h038);
               cap_d = disp_data; cap_rs = disp_rs; cap_long = e[9];
               nwr++; have_wr = 1; lo_run = 1; post = 1;
            end else begin
               lo_run++;
               if (have_wr) post++;
            end
            if (have_wr && post >= 2 && post <= P_HOLD)
               chk(disp_data == cap_d && disp_rs == cap_rs, "R5 hold after fall",
                   {disp_rs, disp_data}, {cap_rs, cap_d});
            if (have_wr && post == P_HOLD + 1)
               chk(disp_data == 0 && disp_rs == 0, "R5 return to zero", {disp_rs, disp_data}, 0);
            if (done && !done_q)
               chk(nwr == N_WR && post == P_HOLD + P_SHORT + 1, "R9 done timing",
                   post, P_HOLD + P_SHORT + 1);
            if (done_q && post == P_HOLD + P_SHORT + 1 + AFTER_DONE) begin
               chk(done && disp_data == 0 && !disp_rs && nwr == N_WR, "R9 idle after done",
                   {done, disp_rs, disp_data}, 9'h100);
               fin = 1;
            end
         end
         prev_en = disp_en; prev_d = disp_data; prev_rs = disp_rs; done_q = done;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      #(CLK_PER/4) rst_n = 1'b1;
      while (nwr < 5 && cyc < LIMIT) @(negedge clk);
      repeat (3) @(negedge clk);
      #(CLK_PER/4) rst_n = 1'b0;
      second_run = 1;
      repeat (4) @(negedge clk);
      #(CLK_PER/4) rst_n = 1'b1;
      while (!fin && cyc < LIMIT) @(negedge clk);
      if (!fin) begin
         wd_bad = 1;
         $display("FAIL R9 watchdog: actual=%0d expected<%0d cycles", cyc, LIMIT);
      end
      $display("  test done: total=%0d bad=%0d", nchk + wd_bad, nbad + wd_bad);
      $finish;
   end

endmodule